// File: doc/BRIEF.md
# Display Controller Power-Up Sequencer

This block brings a small 128x128 TFT panel controller out of power-off and leaves it ready for 16-bit colour pixels. After a `start` pulse it first drives the panel's hardware reset pin low and lets the panel settle. It then produces the whole configuration command stream as a byte-wide stream toward a serial link layer. Each byte is marked as either a command opcode or a parameter. Between selected commands it pauses for timed waits. The wait lengths are counted in clock cycles and derived from the clock frequency parameter.

The stream ends with the memory-write opcode, so the link stays open and pixel data can follow at once. A `done` flag then stays high until the next `start`. All bytes move over a valid/ready handshake, and a byte counts as accepted only in a cycle where both are high.

Top module: `lcd_boot_seq`

## Requirements
- R1: Out of reset and until a start is seen, `tx_valid` is 0, `lcd_rst_n` is 1 and `done` is 0.
- R2: On the clock edge that accepts `start`, `lcd_rst_n` goes low for exactly Nlow cycles and then returns high. No byte is offered before a further Nsettle cycles have elapsed.
- R3: Every duration is N = max(1, ceil(CLK_HZ x time)). The times are RESET_LOW_US microseconds (Nlow), SETTLE_MS (Nsettle), SOFT_RESET_MS (Nsoft) and WAKE_MS (Nwake) milliseconds. The Nsoft pause begins the cycle after opcode 0x01 is accepted. The Nwake pause begins the cycle after opcode 0x11 is accepted.
- R4: 37 bytes are offered, in this order, with `tx_is_data` = 0 on opcodes and 1 on parameters:
  - 0x01
  - 0x11
  - 0x3A 55
  - 0x26 02
  - 0x13
  - 0xB6 FF 06
  - 0xB1 08 02
  - 0xB4 07
  - 0xC0 0A 02
  - 0xC1 02
  - 0xC5 50 63
  - 0xC7 00
  - 0x2A 00 00 00 80
  - 0x2B 00 00 00 80
  - 0x29
  - 0x2C
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_byte` and `tx_is_data` hold. When both are high, the next step follows on the next cycle.
- R6: `done` rises the cycle after the final byte (0x2C) is accepted. It stays high, with `tx_valid` low and `lcd_rst_n` high, until the next start.
- R7: `start` has no effect while a sequence is in progress.
- R8: A start while `done` is high clears `done` and replays the full sequence from the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the power-up sequence |
| tx_ready | input | 1 | Link layer can take a byte |
| tx_valid | output | 1 | A byte is offered |
| tx_byte | output | 8 | Offered byte |
| tx_is_data | output | 1 | 0 = opcode, 1 = parameter |
| lcd_rst_n | output | 1 | Panel hardware reset, active low |
| done | output | 1 | Sequence complete |

## Verification
The two functions that can land in the same cycle are the handling of `start` and the forward step of the sequence. A step forward is either a byte accepted over the handshake or a wait that expires. The bench raises `start` at random throughout a run while `tx_ready` toggles at random. This makes `start` coincide with accepted bytes, stalled bytes and expiring waits, including the final acceptance that sets `done`. A behavioural reference model compares every output on every clock, so any restart, skipped byte or shifted wait shows up as a mismatch in that cycle.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

   typedef enum logic [1:0] {
      K_PIN  = 2'd0,   // hold panel reset low
      K_WAIT = 2'd1,   // timed pause, val selects duration
      K_CMD  = 2'd2,   // opcode byte
      K_DAT  = 2'd3    // parameter byte
   } kind_e;

   typedef struct packed {
      kind_e      kind;
      logic [7:0] val;
   } step_t;

   localparam int STEPS = 41;

   // duration selectors carried in val of pause steps
   localparam logic [7:0] SEL_LOW    = 8'd0;
   localparam logic [7:0] SEL_SETTLE = 8'd1;
   localparam logic [7:0] SEL_SOFT   = 8'd2;
   localparam logic [7:0] SEL_WAKE   = 8'd3;

   function automatic longint cycles_for(longint hz, longint amount, longint per_sec);
      longint n;
      n = (hz * amount + per_sec - 1) / per_sec;
      return (n < 1) ? 64'sd1 : n;
   endfunction

   function automatic step_t script_at(int unsigned i);
      case (i)
         0:  return '{K_PIN,  SEL_LOW};
         1:  return '{K_WAIT, SEL_SETTLE};
         2:  return '{K_CMD,  8'h01};
         3:  return '{K_WAIT, SEL_SOFT};
         4:  return '{K_CMD,  8'h11};
         5:  return '{K_WAIT, SEL_WAKE};
         6:  return '{K_CMD,  8'h3A};
         7:  return '{K_DAT,  8'h55};
         8:  return '{K_CMD,  8'h26};
         9:  return '{K_DAT,  8'h02};
         10: return '{K_CMD,  8'h13};
         11: return '{K_CMD,  8'hB6};
         12: return '{K_DAT,  8'hFF};
         13: return '{K_DAT,  8'h06};
         14: return '{K_CMD,  8'hB1};
         15: return '{K_DAT,  8'h08};
         16: return '{K_DAT,  8'h02};
         17: return '{K_CMD,  8'hB4};
         18: return '{K_DAT,  8'h07};
         19: return '{K_CMD,  8'hC0};
         20: return '{K_DAT,  8'h0A};
         21: return '{K_DAT,  8'h02};
         22: return '{K_CMD,  8'hC1};
         23: return '{K_DAT,  8'h02};
         24: return '{K_CMD,  8'hC5};
         25: return '{K_DAT,  8'h50};
         26: return '{K_DAT,  8'h63};
         27: return '{K_CMD,  8'hC7};
         28: return '{K_DAT,  8'h00};
         29: return '{K_CMD,  8'h2A};
         30, 31, 32, 35, 36, 37: return '{K_DAT, 8'h00};
         33, 38: return '{K_DAT, 8'h80};
         34: return '{K_CMD,  8'h2B};
         39: return '{K_CMD,  8'h29};
         40: return '{K_CMD,  8'h2C};
         default: return '{K_CMD, 8'h00};
      endcase
   endfunction

endpackage

// File: rtl/lbs_script.sv
module lbs_script
   import lbs_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic [IDX_W-1:0] idx,
   output step_t            step
);
   initial begin
      a_r4_idx_width: assert ((1 << IDX_W) >= STEPS);
   end

   assign step = script_at(32'(idx));
endmodule

// File: rtl/lbs_timer.sv
module lbs_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - W'(1);
   end

   assign expired = (cnt == '0);

   // R3: a running pause shortens by exactly one each cycle
   a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq
   import lbs_pkg::*;
#(
   parameter longint CLK_HZ        = 50_000_000,
   parameter longint RESET_LOW_US  = 10,
   parameter longint SETTLE_MS     = 120,
   parameter longint SOFT_RESET_MS = 500,
   parameter longint WAKE_MS       = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       tx_ready,
   output logic       tx_valid,
   output logic [7:0] tx_byte,
   output logic       tx_is_data,
   output logic       lcd_rst_n,
   output logic       done
);
   localparam longint N_LOW    = cycles_for(CLK_HZ, RESET_LOW_US, 1_000_000);
   localparam longint N_SETTLE = cycles_for(CLK_HZ, SETTLE_MS, 1_000);
   localparam longint N_SOFT   = cycles_for(CLK_HZ, SOFT_RESET_MS, 1_000);
   localparam longint N_WAKE   = cycles_for(CLK_HZ, WAKE_MS, 1_000);
   localparam longint M_A      = (N_LOW > N_SETTLE) ? N_LOW : N_SETTLE;
   localparam longint M_B      = (N_SOFT > N_WAKE) ? N_SOFT : N_WAKE;
   localparam longint N_MAX    = (M_A > M_B) ? M_A : M_B;
   localparam int     CNT_W    = (N_MAX < 2) ? 1 : $clog2(N_MAX);
   localparam int     IDX_W    = $clog2(STEPS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

   initial begin
      a_r3_params: assert (CLK_HZ > 0 && RESET_LOW_US > 0 && SETTLE_MS >= 0
                           && SOFT_RESET_MS >= 0 && WAKE_MS >= 0);
   end

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

   state_e            state;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  rom_idx  [2];
   step_t             rom_step [2];
   logic              expired;
   logic              is_byte;
   logic              advance;
   logic              load;
   logic [CNT_W-1:0]  load_val;

   // slot 0 reads the active step, slot 1 the step that follows
   assign rom_idx[0] = idx;
   assign rom_idx[1] = (state == S_RUN) ? idx + IDX_W'(1) : '0;

   for (genvar g = 0; g < 2; g++) begin : g_rom
      lbs_script #(.IDX_W(IDX_W)) i_script (
         .idx  (rom_idx[g]),
         .step (rom_step[g])
      );
   end

   function automatic logic [CNT_W-1:0] pause_len(step_t s);
      if (s.kind == K_CMD || s.kind == K_DAT) return '0;
      case (s.val)
         SEL_LOW:    return CNT_W'(N_LOW - 1);
         SEL_SETTLE: return CNT_W'(N_SETTLE - 1);
         SEL_SOFT:   return CNT_W'(N_SOFT - 1);
         SEL_WAKE:   return CNT_W'(N_WAKE - 1);
         default:    return '0;
      endcase
   endfunction

   assign is_byte  = (rom_step[0].kind == K_CMD) || (rom_step[0].kind == K_DAT);
   assign advance  = (state == S_RUN) && (is_byte ? tx_ready : expired);
   assign load     = ((state != S_RUN) && start) || (advance && idx != LAST_IDX);
   assign load_val = pause_len(rom_step[1]);

   lbs_timer #(.W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         idx   <= '0;
      end else begin
         case (state)
            S_RUN:
               if (advance) begin
                  if (idx == LAST_IDX) begin
                     state <= S_FIN;
                     idx   <= '0;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
            default:
               if (start) begin
                  state <= S_RUN;
                  idx   <= '0;
               end
         endcase
      end
   end

   assign tx_valid   = (state == S_RUN) && is_byte;
   assign tx_byte    = tx_valid ? rom_step[0].val : 8'h00;
   assign tx_is_data = tx_valid && (rom_step[0].kind == K_DAT);
   assign lcd_rst_n  = !((state == S_RUN) && (rom_step[0].kind == K_PIN));
   assign done       = (state == S_FIN);

   // R5: stalled byte is held unchanged
   a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_is_data)));
   // R2: nothing is offered while the panel sits in reset
   a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_rst_n |-> !tx_valid);
   // R6: finished state is quiet
   a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!tx_valid && lcd_rst_n));
   // R6: done only follows an accepted byte
   a_r6_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(tx_valid && tx_ready && tx_byte == 8'h2C));
   // R8: a start while finished clears done and pulls the pin low
   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (!done && !lcd_rst_n));
endmodule

// File: tb/test_lcd_boot_seq.sv
module test_lcd_boot_seq;
   localparam longint HZ       = 40_000;
   localparam longint LOW_US   = 100;
   localparam longint SETTLE   = 120;
   localparam longint SOFT     = 500;
   localparam longint WAKE     = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       tx_ready = 1'b0;
   logic       tx_valid;
   logic [7:0] tx_byte;
   logic       tx_is_data;
   logic       lcd_rst_n;
   logic       done;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int accepted = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   lcd_boot_seq #(
      .CLK_HZ(HZ), .RESET_LOW_US(LOW_US), .SETTLE_MS(SETTLE),
      .SOFT_RESET_MS(SOFT), .WAKE_MS(WAKE)
   ) i_lcd_boot_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_ready(tx_ready),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_is_data(tx_is_data),
      .lcd_rst_n(lcd_rst_n), .done(done)
   );

   // expected script: kind 0 pin-low pause, 1 pause, 2 opcode, 3 parameter
   int q_kind[$];
   int q_val[$];
   int q_len[$];

   function automatic int dur(longint amount, longint per_sec);
      longint n;
      n = (HZ * amount + per_sec - 1) / per_sec;
      return (n < 1) ? 1 : int'(n);
   endfunction

   task automatic put(int k, int v, int l);
      q_kind.push_back(k); q_val.push_back(v); q_len.push_back(l);
   endtask

   task automatic op(int v);  put(2, v, 0); endtask
   task automatic prm(int v); put(3, v, 0); endtask

   initial begin
      put(0, 0, dur(LOW_US, 1_000_000));
      put(1, 0, dur(SETTLE, 1_000));
      op(8'h01); put(1, 0, dur(SOFT, 1_000));
      op(8'h11); put(1, 0, dur(WAKE, 1_000));
      op(8'h3A); prm(8'h55);
      op(8'h26); prm(8'h02);
      op(8'h13);
      op(8'hB6); prm(8'hFF); prm(8'h06);
      op(8'hB1); prm(8'h08); prm(8'h02);
      op(8'hB4); prm(8'h07);
      op(8'hC0); prm(8'h0A); prm(8'h02);
      op(8'hC1); prm(8'h02);
      op(8'hC5); prm(8'h50); prm(8'h63);
      op(8'hC7); prm(8'h00);
      op(8'h2A); prm(0); prm(0); prm(0); prm(8'h80);
      op(8'h2B); prm(0); prm(0); prm(0); prm(8'h80);
      op(8'h29);
      op(8'h2C);
   end

   // reference model: 0 idle, 1 running, 2 finished
   int m_st = 0;
   int m_i = 0;
   int m_left = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_i = 0; m_left = 0;
      end else if (m_st != 1) begin
         if (start) begin
            m_st = 1; m_i = 0; m_left = q_len[0];
         end
      end else begin
         bit step_on;
         if (q_kind[m_i] < 2) begin
            step_on = (m_left == 1);
            if (!step_on) m_left--;
         end else begin
            step_on = tx_ready;
            if (tx_ready) accepted++;
         end
         if (step_on) begin
            if (m_i == q_kind.size() - 1) begin
               m_st = 2;
            end else begin
               m_i++;
               m_left = q_len[m_i];
            end
         end
      end
   end

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // compare every output each cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit e_valid, e_pin, e_done;
         e_valid = (m_st == 1) && (q_kind[m_i] >= 2);
         e_pin   = !((m_st == 1) && (q_kind[m_i] == 0));
         e_done  = (m_st == 2);
         check(tx_valid == e_valid, "R4/R5 tx_valid", tx_valid, e_valid);
         check(lcd_rst_n == e_pin, "R2 lcd_rst_n", lcd_rst_n, e_pin);
         check(done == e_done, "R6 done", done, e_done);
         if (e_valid) begin
            check(tx_byte == q_val[m_i][7:0], "R4 tx_byte", tx_byte, q_val[m_i]);
            check(tx_is_data == (q_kind[m_i] == 3), "R4 tx_is_data", tx_is_data,
                  q_kind[m_i] == 3);
         end
      end
   end

   task automatic finish_run();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190_000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired at cycle %0d", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check(tx_valid == 1'b0 && lcd_rst_n == 1'b1 && done == 1'b0,
            "R1 reset outputs", {tx_valid, lcd_rst_n, done}, 3'b010);
      rst_n <= 1'b1;
      repeat (20) @(negedge clk);
      check(tx_valid == 1'b0 && lcd_rst_n == 1'b1 && done == 1'b0,
            "R1 idle outputs", {tx_valid, lcd_rst_n, done}, 3'b010);

      // run 1: random backpressure, random start pulses mid-run (R7, R5)
      start <= 1'b1;
      @(negedge clk);
      start <= 1'b0;
      accepted = 0;
      while (!done) begin
         tx_ready <= ($urandom % 10) < 6;
         start    <= !done && (($urandom % 8) == 0);
         @(negedge clk);
      end
      start <= 1'b0;
      tx_ready <= 1'b0;
      check(accepted == 37, "R4 byte count run 1", accepted, 37);

      // R6: done holds while idle, even with ready high
      repeat (30) begin
         tx_ready <= 1'b1;
         @(negedge clk);
      end
      check(done == 1'b1, "R6 done held", done, 1);

      // R8: restart replays the whole sequence, ready always high
      accepted = 0;
      start <= 1'b1;
      @(negedge clk);
      start <= 1'b0;
      check(done == 1'b0 && lcd_rst_n == 1'b0, "R8 restart",
            {done, lcd_rst_n}, 2'b00);
      while (!done) @(negedge clk);
      check(accepted == 37, "R8 byte count run 2", accepted, 37);
      // R3: timing itself is covered cycle by cycle by the model comparison
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule